// File: doc/BRIEF.md
# Signed Multi-Format Scanned Four-Digit Display Driver

This block sits on the processor's shared byte bus and holds one data byte in a register of its own. The register changes only when the load strobe is high at a clock edge. The block shows that byte on a four-digit multiplexed seven-segment display.

Two live mode inputs set how the byte is read. One selects decimal or hexadecimal. The other selects plain unsigned or two's complement. When the signed reading is negative, the leftmost digit shows a minus bar and the other digits show the magnitude.

The digits are lit one at a time in a fixed rotation. The rotation advances once per tick of a free-running prescaler. Segment outputs and digit enables are both active-high. Decimal conversion is combinational, using the shift-and-add-3 method.

Top module: `numview_top`

## Requirements
- R1: After reset the held byte is 0 and digit 0 (the rightmost digit) is enabled alone. With both modes at 0, digit 0 shows the "0" glyph and digits 1 to 3 are blank (segment code 0).
- R2: The held byte takes the bus value at a clock edge where `load` is 1. At all other edges it keeps its value, whatever the bus carries.
- R3: Exactly one bit of `dig_en` is high at all times. Every `TICK_DIV` clock cycles the enabled digit moves from digit k to digit k+1, and from digit 3 back to digit 0.
- R4: In unsigned decimal mode (`hex_mode`=0, `signed_mode`=0) the value 0 to 255 is shown right-aligned in digits 0 to 2, with leading zeros blanked. Digit 3 is blank.
- R5: In signed decimal mode, a byte with bit 7 set shows the minus glyph (segment code 0x40) on digit 3. Its magnitude, 1 to 128, is shown right-aligned with leading zeros blanked.
- R6: In signed decimal mode, a byte with bit 7 clear is shown exactly as in unsigned decimal mode.
- R7: In hex mode, when the value is non-negative or `signed_mode` is 0, digit 1 shows the high nibble and digit 0 shows the low nibble. Both are always shown, so zero shows "00". Digits 2 and 3 are blank.
- R8: In signed hex mode, a byte with bit 7 set shows the minus glyph on digit 3. Its magnitude is shown as two hex digits on digits 1 and 0, and digit 2 is blank.
- R9: `seg` bit 0 drives segment a, and so on up to bit 6, which drives segment g. The glyph codes for 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. Minus is 40 and blank is 00.
- R10: A change of `hex_mode` or `signed_mode` takes effect on the display without a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DATA_W | Shared data bus |
| load | input | 1 | Capture strobe for the held byte |
| hex_mode | input | 1 | 1 = hexadecimal, 0 = decimal |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| seg | output | 7 | Segment drive for the enabled digit, bit 0 = a |
| dig_en | output | DIGITS | One-hot, active-high digit enable, bit 0 = rightmost |

## Verification
The value patterns cover all four mode combinations:
- Zero, a single digit, two digits and three digits tell right alignment apart from leading-zero blanking.
- 100 and 255 check the hundreds carry of the add-3 stage.
- 127, -1, -10 and -128 separate the sign bit from the magnitude, including the one magnitude that needs three digits.
- In hex, a positive signed value, a negative signed value, 0x80, and letter nibbles check nibble order, negation and the A to F glyphs.

Directed tests then hold the byte while the bus changes, switch modes without a load, and trace the scan rotation over many prescaler ticks.

// File: rtl/numview_pkg.sv
package numview_pkg;

   localparam int SEG_W = 7;

   typedef enum logic [1:0] {
      DK_BLANK = 2'd0,
      DK_MINUS = 2'd1,
      DK_NUM   = 2'd2
   } dkind_e;

   typedef struct packed {
      dkind_e     kind;
      logic [3:0] nib;
   } dcode_t;

   // segment order: bit0 = a ... bit6 = g, active high
   function automatic logic [SEG_W-1:0] glyph(input dcode_t c);
      logic [SEG_W-1:0] s;
      s = '0;
      if (c.kind == DK_MINUS) begin
         s = 7'h40;
      end else if (c.kind == DK_NUM) begin
         case (c.nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/numview_tick.sv
module numview_tick #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("numview_tick: DIV must be at least 1");
      end

      if (DIV == 1) begin : g_every
         logic run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run_q <= 1'b0;
            else        run_q <= 1'b1;
         end
         assign tick = run_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (cnt_q == CW'(DIV - 1))    cnt_q <= '0;
            else                               cnt_q <= cnt_q + CW'(1);
         end
         assign tick = (cnt_q == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/numview_scan.sv
module numview_scan #(
   parameter int DIGITS = 4,
   localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   output logic [SEL_W-1:0]  sel,
   output logic [DIGITS-1:0] dig_en
);
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (tick) begin
         if (sel_q == SEL_W'(DIGITS - 1)) sel_q <= '0;
         else                             sel_q <= sel_q + SEL_W'(1);
      end
   end

   assign sel = sel_q;

   always_comb begin
      dig_en = '0;
      for (int k = 0; k < DIGITS; k++) begin
         if (sel_q == SEL_W'(k)) dig_en[k] = 1'b1;
      end
   end
endmodule

// File: rtl/numview_bcd.sv
module numview_bcd #(
   parameter int W  = 8,
   parameter int ND = 3
) (
   input  logic [W-1:0]    bin,
   output logic [ND*4-1:0] bcd
);
   always_comb begin
      logic [ND*4-1:0] acc;
      acc = '0;
      for (int i = W - 1; i >= 0; i--) begin
         for (int d = 0; d < ND; d++) begin
            if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
         end
         acc = {acc[ND*4-2:0], bin[i]};
      end
      bcd = acc;
   end
endmodule

// File: rtl/numview_layout.sv
module numview_layout
   import numview_pkg::*;
#(
   parameter int W      = 8,
   parameter int DIGITS = 4
) (
   input  logic                      [W-1:0] val,
   input  logic                              hex_mode,
   input  logic                              signed_mode,
   output dcode_t [DIGITS-1:0]               codes
);
   localparam int BCD_N = ((W * 301) / 1000) + 1;
   localparam int HEX_N = (W + 3) / 4;
   localparam int HX_W  = HEX_N * 4;

   generate
      if (DIGITS < BCD_N + 1 || DIGITS < HEX_N + 1) begin : g_bad_digits
         $error("numview_layout: too few digits for sign plus magnitude");
      end
   endgenerate

   logic             neg;
   logic [W-1:0]     mag;
   logic [HX_W-1:0]  hx;
   logic [BCD_N*4-1:0] dec;

   assign neg = signed_mode & val[W-1];
   assign mag = neg ? (~val + W'(1)) : val;
   assign hx  = HX_W'(mag);

   numview_bcd #(.W(W), .ND(BCD_N)) bcd_i (
      .bin (mag),
      .bcd (dec)
   );

   always_comb begin
      int hi;
      for (int d = 0; d < DIGITS; d++) codes[d] = '{kind: DK_BLANK, nib: 4'h0};
      hi = 0;
      if (hex_mode) begin
         for (int d = 0; d < HEX_N; d++) codes[d] = '{kind: DK_NUM, nib: hx[d*4 +: 4]};
      end else begin
         for (int d = 0; d < BCD_N; d++) begin
            if (dec[d*4 +: 4] != 4'd0) hi = d;
         end
         for (int d = 0; d < BCD_N; d++) begin
            if (d <= hi) codes[d] = '{kind: DK_NUM, nib: dec[d*4 +: 4]};
         end
      end
      if (neg) codes[DIGITS-1] = '{kind: DK_MINUS, nib: 4'h0};
   end
endmodule

// File: rtl/numview_top.sv
module numview_top
   import numview_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIGITS   = 4,
   parameter int TICK_DIV = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              load,
   input  logic              hex_mode,
   input  logic              signed_mode,
   output logic [6:0]        seg,
   output logic [DIGITS-1:0] dig_en
);
   localparam int SEL_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("numview_top: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0]  val_q;
   logic               tick;
   logic [SEL_W-1:0]   sel;
   dcode_t [DIGITS-1:0] codes;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= '0;
      else if (load) val_q <= bus_data;
   end

   numview_tick #(.DIV(TICK_DIV)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   numview_scan #(.DIGITS(DIGITS)) scan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .sel    (sel),
      .dig_en (dig_en)
   );

   numview_layout #(.W(DATA_W), .DIGITS(DIGITS)) layout_i (
      .val         (val_q),
      .hex_mode    (hex_mode),
      .signed_mode (signed_mode),
      .codes       (codes)
   );

   assign seg = glyph(codes[sel]);
endmodule

// File: rtl/numview_chk.sv
module numview_chk #(
   parameter int DATA_W = 8,
   parameter int DIGITS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] bus_data,
   input logic              load,
   input logic              hex_mode,
   input logic              signed_mode,
   input logic [6:0]        seg,
   input logic [DIGITS-1:0] dig_en,
   input logic [DATA_W-1:0] shown,
   input logic              tick
);
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> shown == $past(bus_data));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shown));

   a_r3_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_en) == 1);

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> dig_en == {$past(dig_en[DIGITS-2:0]), $past(dig_en[DIGITS-1])});

   a_r3_dwell: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(dig_en));

   a_r5_minus: assert property (@(posedge clk) disable iff (!rst_n)
      (signed_mode && shown[DATA_W-1] && dig_en[DIGITS-1]) |-> seg == 7'h40);

   // R4 and R7: top digit stays dark without a sign
   a_r4_top_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (!signed_mode && dig_en[DIGITS-1]) |-> seg == 7'h00);

   a_r8_hex_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (hex_mode && dig_en[2]) |-> seg == 7'h00);
endmodule

bind numview_top numview_chk #(.DATA_W(DATA_W), .DIGITS(DIGITS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_data    (bus_data),
   .load        (load),
   .hex_mode    (hex_mode),
   .signed_mode (signed_mode),
   .seg         (seg),
   .dig_en      (dig_en),
   .shown       (val_q),
   .tick        (tick)
);

// File: tb/numview_top_tb_top.sv
module numview_top_tb_top;
   localparam int TDIV = 4;
   localparam int ND   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_data = 8'h00;
   logic       load = 1'b0;
   logic       hex_mode = 1'b0;
   logic       signed_mode = 1'b0;
   logic [6:0] seg;
   logic [3:0] dig_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [6:0] shot [4];

   always #2 clk = ~clk;

   numview_top #(.DATA_W(8), .DIGITS(ND), .TICK_DIV(TDIV)) dut_i (
      .clk (clk), .rst_n (rst_n), .bus_data (bus_data), .load (load),
      .hex_mode (hex_mode), .signed_mode (signed_mode),
      .seg (seg), .dig_en (dig_en)
   );

   // {value, hex, signed, digit3, digit2, digit1, digit0}
   localparam logic [37:0] VEC [15] = '{
      {8'h00, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h3F},
      {8'h07, 1'b0, 1'b0, 7'h00, 7'h00, 7'h00, 7'h07},
      {8'h2A, 1'b0, 1'b0, 7'h00, 7'h00, 7'h66, 7'h5B},
      {8'hFF, 1'b0, 1'b0, 7'h00, 7'h5B, 7'h6D, 7'h6D},
      {8'h64, 1'b0, 1'b0, 7'h00, 7'h06, 7'h3F, 7'h3F},
      {8'hFF, 1'b0, 1'b1, 7'h40, 7'h00, 7'h00, 7'h06},
      {8'h80, 1'b0, 1'b1, 7'h40, 7'h06, 7'h5B, 7'h7F},
      {8'h7F, 1'b0, 1'b1, 7'h00, 7'h06, 7'h5B, 7'h07},
      {8'hF6, 1'b0, 1'b1, 7'h40, 7'h00, 7'h06, 7'h3F},
      {8'h00, 1'b1, 1'b0, 7'h00, 7'h00, 7'h3F, 7'h3F},
      {8'hAB, 1'b1, 1'b0, 7'h00, 7'h00, 7'h77, 7'h7C},
      {8'hC3, 1'b1, 1'b1, 7'h40, 7'h00, 7'h4F, 7'h5E},
      {8'h5E, 1'b1, 1'b1, 7'h00, 7'h00, 7'h6D, 7'h79},
      {8'h80, 1'b1, 1'b1, 7'h40, 7'h00, 7'h7F, 7'h3F},
      {8'hF0, 1'b1, 1'b0, 7'h00, 7'h00, 7'h71, 7'h3F}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // sample every digit across a full scan, away from the active edge
   task automatic capture();
      for (int k = 0; k < 4; k++) shot[k] = 7'h7F;
      for (int n = 0; n < ND * TDIV + 2; n++) begin
         @(negedge clk);
         for (int k = 0; k < 4; k++) if (dig_en == 4'(1 << k)) shot[k] = seg;
      end
   endtask

   task automatic put(input logic [7:0] v);
      @(negedge clk);
      bus_data = v;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 enable", 32'(dig_en), 32'h1);
      capture();
      check("R1 d0", 32'(shot[0]), 32'h3F);
      check("R1 d1", 32'(shot[1]), 32'h00);
      check("R1 d2", 32'(shot[2]), 32'h00);
      check("R1 d3", 32'(shot[3]), 32'h00);

      foreach (VEC[i]) begin
         logic [7:0] v;
         logic h, s;
         string tag;
         v = VEC[i][37:30];
         h = VEC[i][29];
         s = VEC[i][28];
         if (h) tag = (s && v[7]) ? "R8 R9" : "R7 R9";
         else if (s) tag = v[7] ? "R5 R9" : "R6 R9";
         else tag = "R4 R9";
         hex_mode = h;
         signed_mode = s;
         put(v);
         capture();
         for (int k = 0; k < 4; k++)
            check($sformatf("%s vec%0d digit%0d", tag, i, k), 32'(shot[k]), 32'(VEC[i][k*7 +: 7]));
      end

      // R2: bus changes without strobe leave the display alone
      hex_mode = 1'b0;
      signed_mode = 1'b0;
      put(8'h2A);
      @(negedge clk);
      bus_data = 8'hFF;
      repeat (3) @(negedge clk);
      capture();
      check("R2 hold d0", 32'(shot[0]), 32'h5B);
      check("R2 hold d1", 32'(shot[1]), 32'h66);
      check("R2 hold d2", 32'(shot[2]), 32'h00);
      put(8'h09);
      capture();
      check("R2 reload d0", 32'(shot[0]), 32'h6F);
      check("R2 reload d1", 32'(shot[1]), 32'h00);

      // R10: modes act without a new load
      put(8'hFF);
      capture();
      check("R10 unsigned d3", 32'(shot[3]), 32'h00);
      check("R10 unsigned d2", 32'(shot[2]), 32'h5B);
      signed_mode = 1'b1;
      capture();
      check("R10 signed d3", 32'(shot[3]), 32'h40);
      check("R10 signed d0", 32'(shot[0]), 32'h06);
      hex_mode = 1'b1;
      signed_mode = 1'b0;
      capture();
      check("R10 hex d1", 32'(shot[1]), 32'h71);
      check("R10 hex d0", 32'(shot[0]), 32'h71);

      // R3: rotation by one, one-hot, once every TDIV cycles
      begin
         logic [3:0] prev;
         int changes;
         int bad_onehot;
         int bad_step;
         changes = 0;
         bad_onehot = 0;
         bad_step = 0;
         @(negedge clk);
         prev = dig_en;
         for (int n = 0; n < 8 * TDIV; n++) begin
            @(negedge clk);
            if ($countones(dig_en) != 1) bad_onehot++;
            if (dig_en != prev) begin
               changes++;
               if (dig_en != {prev[2:0], prev[3]}) bad_step++;
            end
            prev = dig_en;
         end
         check("R3 changes", 32'(changes), 32'd8);
         check("R3 onehot", 32'(bad_onehot), 32'd0);
         check("R3 rotate", 32'(bad_step), 32'd0);
      end

      finish_run();
   end
endmodule